// File: doc/BRIEF.md
# Multi-Domain Power-On Reset Sequencer

This block produces one active-high reset for each of several clock domains once the device has come out of start-up. Power-up register values alone are not enough at start-up. The internal write enable that starts the user logic is slow, and it is skewed against the user clocks. For that reason every domain receives an explicit reset, and that reset is released only after the clock generator reports lock, every extra qualifier input is true, and no external reset request is pending.

Each domain brings the combined qualifier into its own clock through a two-flop synchronizer. It then runs a hold-off counter of its own, with a per-domain length, and passes the resulting release through a reset bridge clocked by that domain. Reset therefore asserts asynchronously and deasserts on an edge of the domain's own clock. When lock is lost or an external request arrives, every output reasserts at once, with no clock needed, and the whole sequence starts again.

Top module: `rstseq_top`

## Requirements
- R1: Every reset output is high from time zero, before any clock edge, and stays high for as long as the lock input is low.
- R2: Define the arm condition as lock high, all qualifier inputs high and the external request low. Domain d's output falls on exactly the (HOLD_d + 2 + SYNC_STAGES)-th rising edge of its own clock, counting from the first edge that samples the arm condition true. The 2 is the qualifier synchronizer.
- R3: A falling lock input drives all reset outputs high immediately, without waiting for a clock edge.
- R4: A high external reset request drives all reset outputs high immediately. When the request is removed, the full sequence of R2 runs again.
- R5: A domain's hold-off counter stays at zero while its synchronized arm condition is false. Otherwise it advances by one per clock, stops at HOLD_d and never exceeds it.
- R6: While any single qualifier input is low, all reset outputs stay high, whatever the state of lock.
- R7: If a qualifier falls after release, with lock high and no request, a domain's output does not rise at once. It rises on its own clock within 2 + SYNC_STAGES edges, and a released output stays low while the arm condition holds.
- R8: Hold-off lengths are independent per domain, and a hold-off of zero is legal. That domain then releases after 2 + SYNC_STAGES edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dom_clk | input | NUM_DOM | One clock per domain |
| lock_in | input | 1 | Clock generator lock indication, asynchronous |
| ext_rst_req | input | 1 | External reset request, active high, asynchronous |
| qual_in | input | NUM_QUAL | Extra release qualifiers, all must be high |
| dom_rst | output | NUM_DOM | Active-high reset per domain, released on that domain's clock |

## Verification
The bench builds three domains whose clocks run at 5, 7 and 11 ns, with hold-offs of 9, 4 and 0 cycles, two qualifiers and two bridge stages. Because the clocks are mutually unrelated, each release edge count is checked in its own domain, and release order differs from domain index. The zero hold-off brings the bare synchronizer latency within reach. Lock, request and qualifier changes fall between clock edges, which makes the asynchronous assertion distinguishable from the clocked reassertion on qualifier loss.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

  localparam int unsigned HOLD_VEC_MAX = 256;

  // Combined arm condition seen by every domain before synchronization.
  function automatic logic arm_ok(input logic lock, input logic quals_all, input logic req);
    return lock & quals_all & ~req;
  endfunction

  // Extract the hold-off of domain idx from a packed vector of w-bit fields.
  function automatic int unsigned pick_hold(input logic [HOLD_VEC_MAX-1:0] vec,
                                            input int unsigned idx,
                                            input int unsigned w);
    int unsigned r;
    r = 0;
    for (int unsigned b = 0; b < 32; b++) begin
      if (b < w) r[b] = vec[idx*w + b];
    end
    return r;
  endfunction

  // Edges from first armed sample to release: qualifier sync + hold-off + bridge.
  function automatic int unsigned release_edges(input int unsigned hold, input int unsigned stages);
    return hold + 2 + stages;
  endfunction

endpackage

// File: rtl/rstseq_bitsync.sv
`timescale 1ns/1ps
module rstseq_bitsync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        CLR_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg = {STAGES{CLR_VAL}};

  always_ff @(posedge clk or posedge clr) begin
    if (clr) shreg <= {STAGES{CLR_VAL}};
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/rstseq_holdoff.sv
`timescale 1ns/1ps
module rstseq_holdoff #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned HOLD  = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt_q = '0;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)                   cnt_q <= '0;
    else if (!en)              cnt_q <= '0;
    else if (cnt_q != HOLD_C)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign done = en && (cnt_q == HOLD_C);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= HOLD_C);
  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (clr)
    !en |=> (cnt_q == '0));
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (clr)
    (en && cnt_q != HOLD_C) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rstseq_domain.sv
`timescale 1ns/1ps
module rstseq_domain #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned HOLD        = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic abort,
  input  logic arm_raw,
  output logic rst_o
);
  logic             arm_sync;
  logic [CNT_W-1:0] hold_cnt;
  logic             hold_done;

  rstseq_bitsync #(.STAGES(2), .CLR_VAL(1'b0)) u_arm_sync (
    .clk(clk), .clr(abort), .d(arm_raw), .q(arm_sync)
  );

  rstseq_holdoff #(.CNT_W(CNT_W), .HOLD(HOLD)) u_holdoff (
    .clk(clk), .clr(abort), .en(arm_sync), .cnt(hold_cnt), .done(hold_done)
  );

  rstseq_bitsync #(.STAGES(SYNC_STAGES), .CLR_VAL(1'b1)) u_bridge (
    .clk(clk), .clr(abort), .d(~hold_done), .q(rst_o)
  );

  assert_abort_holds_R3: assert property (@(posedge clk)
    abort |-> rst_o);
  assert_release_gated_R6: assert property (@(posedge clk) disable iff (abort)
    $fell(rst_o) |-> arm_sync);
  assert_stay_released_R7: assert property (@(posedge clk) disable iff (abort)
    (!rst_o && arm_sync && $past(arm_sync)) |=> !rst_o);
  assert_count_at_release_R2: assert property (@(posedge clk) disable iff (abort)
    $fell(rst_o) |-> (hold_cnt == CNT_W'(HOLD)));
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top #(
  parameter int unsigned NUM_DOM     = 3,
  parameter int unsigned NUM_QUAL    = 2,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_DOM*CNT_W-1:0] HOLD_VEC = {8'd6, 8'd12, 8'd3}
) (
  input  logic [NUM_DOM-1:0]  dom_clk,
  input  logic                lock_in,
  input  logic                ext_rst_req,
  input  logic [NUM_QUAL-1:0] qual_in,
  output logic [NUM_DOM-1:0]  dom_rst
);
  localparam int unsigned VEC_W = NUM_DOM * CNT_W;

  if (SYNC_STAGES < 2) begin : g_bad_stages
    $error("SYNC_STAGES must be at least 2");
  end
  if (VEC_W > rstseq_pkg::HOLD_VEC_MAX) begin : g_bad_vec
    $error("NUM_DOM*CNT_W exceeds hold vector capacity");
  end

  // Named events shared by all domains.
  logic abort;
  logic quals_all;
  logic arm_raw;

  assign abort     = ~lock_in | ext_rst_req;
  assign quals_all = &qual_in;
  assign arm_raw   = rstseq_pkg::arm_ok(lock_in, quals_all, ext_rst_req);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam int unsigned HOLD_D =
      rstseq_pkg::pick_hold(rstseq_pkg::HOLD_VEC_MAX'(HOLD_VEC), d, CNT_W);

    rstseq_domain #(
      .CNT_W(CNT_W), .HOLD(HOLD_D), .SYNC_STAGES(SYNC_STAGES)
    ) u_domain (
      .clk(dom_clk[d]), .abort(abort), .arm_raw(arm_raw), .rst_o(dom_rst[d])
    );

    assert_lock_low_R1: assert property (@(posedge dom_clk[d])
      !lock_in |-> dom_rst[d]);
  end
endmodule

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
module rstseq_top_tb;
  localparam int unsigned ND = 3;
  localparam int unsigned NQ = 2;
  localparam int unsigned CW = 8;
  localparam int unsigned SS = 2;
  localparam int HOLD [ND] = '{9, 4, 0};
  localparam real HALF [ND] = '{2.5, 3.5, 5.5};

  logic [ND-1:0] dom_clk = '0;
  logic          lock_in = 1'b0;
  logic          ext_rst_req = 1'b0;
  logic [NQ-1:0] qual_in = '1;
  logic [ND-1:0] dom_rst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 0;
  int exp_q [ND][$];

  rstseq_top #(
    .NUM_DOM(ND), .NUM_QUAL(NQ), .CNT_W(CW), .SYNC_STAGES(SS),
    .HOLD_VEC({8'd0, 8'd4, 8'd9})
  ) u_dut (
    .dom_clk(dom_clk), .lock_in(lock_in), .ext_rst_req(ext_rst_req),
    .qual_in(qual_in), .dom_rst(dom_rst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  for (genvar d = 0; d < ND; d++) begin : g_mon
    initial forever #(HALF[d]) dom_clk[d] = ~dom_clk[d];

    int  edges = 0;
    logic prev = 1'b1;
    // Count edges that sample the arm condition true (expected model of R2).
    always @(posedge dom_clk[d]) begin
      if (lock_in && (&qual_in) && !ext_rst_req) edges <= edges + 1;
      else edges <= 0;
    end
    // Monitor: pop the expected edge count on every observed release.
    always @(negedge dom_clk[d]) begin
      if (prev && !dom_rst[d]) begin
        if (exp_q[d].size() == 0) begin
          check(0, "R2", $sformatf("unexpected release dom%0d", d), edges, -1);
        end else begin
          int e;
          e = exp_q[d].pop_front();
          check(edges == e, "R2/R5/R8", $sformatf("release edge dom%0d", d), edges, e);
        end
      end
      prev <= dom_rst[d];
    end
  end

  // Driver: push one expected release per domain, based on the requirement formula.
  task automatic expect_release();
    for (int d = 0; d < ND; d++) exp_q[d].push_back(HOLD[d] + 2 + SS);
  endtask

  task automatic check_drained(input string req);
    for (int d = 0; d < ND; d++)
      check(exp_q[d].size() == 0, req, $sformatf("pending releases dom%0d", d),
            exp_q[d].size(), 0);
  endtask

  task automatic check_all(input logic v, input string req, input string what);
    for (int d = 0; d < ND; d++)
      check(dom_rst[d] === v, req, $sformatf("%s dom%0d", what, d), int'(dom_rst[d]), int'(v));
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    check(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // Times kept at x.3 ns so no stimulus or check meets a clock edge.
    #0.3;
    check_all(1'b1, "R1", "power-up before first edge");
    #300;
    check_all(1'b1, "R1", "held while lock low");

    // R2 / R8: first release after lock.
    expect_release();
    lock_in = 1'b1;
    #300;
    check_drained("R2");
    check_all(1'b0, "R2", "released after lock");

    // R3: lock loss asserts immediately.
    lock_in = 1'b0;
    #0.1;
    check_all(1'b1, "R3", "async assert on lock loss");
    #99.9;
    expect_release();
    lock_in = 1'b1;
    #300;
    check_drained("R3");

    // R4: external request asserts immediately, sequence repeats.
    ext_rst_req = 1'b1;
    #0.1;
    check_all(1'b1, "R4", "async assert on request");
    #99.9;
    check_all(1'b1, "R4", "held during request");
    expect_release();
    ext_rst_req = 1'b0;
    #300;
    check_drained("R4");
    check_all(1'b0, "R4", "released after request");

    // R7: qualifier loss reasserts on each domain clock, not at once.
    qual_in[0] = 1'b0;
    #0.1;
    check_all(1'b0, "R7", "no async assert on qualifier loss");
    #199.9;
    check_all(1'b1, "R7", "reasserted after qualifier loss");

    // R6: a different single qualifier low still blocks release.
    qual_in = 2'b01;
    #300;
    check_all(1'b1, "R6", "blocked by qualifier 1");
    qual_in = 2'b00;
    #100;
    check_all(1'b1, "R6", "blocked by both qualifiers");
    expect_release();
    qual_in = 2'b11;
    #300;
    check_drained("R6");
    check_all(1'b0, "R6", "released once all qualifiers high");

    // R1: lock low with qualifiers high keeps reset.
    lock_in = 1'b0;
    #300;
    check_all(1'b1, "R1", "held after lock drop");
    finish_run();
  end
endmodule